// File: doc/BRIEF.md
# Double-Word Program Sequencer for a Non-Volatile Array

This block sits between a 32-bit write bus and a small model of a non-volatile array. The array is organised in 64-bit double-words. Every double-word is committed as one 72-bit entry: 64 data bits plus an 8-bit check code. The block builds a double-word from two consecutive 32-bit word writes. The word at the aligned address is the low half and the word 4 bytes above it is the high half. When the second word arrives, the block checks that the cell may be written and then commits the entry.

The block enforces several protection rules. A programmed cell can only be overwritten with zeros. Only full-word writes are accepted, and the pair must be aligned. Two requesters drive the bus: a non-secure one (requester code 0) and a secure one (code 1). When secure mode is on, the non-secure requester cannot write into the secure upper region of the array. An unprivileged write to a privileged page is also refused. Errors are reported through sticky write-1-to-clear flags.

A mass-erase command returns every cell to the erased state, which reads as all ones. A suspend input blocks any operation from starting. If the access rights of the target change between the two halves of a pair, the block locks up with no error flag until reset. A registered read port returns the stored data and check code for any double-word index.

Top module: `dwp_ctrl`

## Requirements
- R1: After reset `busy` is 0, `err_flags` is 0, `illegal_evt` is 0, and every index reads as data all ones with check code 8'hFF (erased).
- R2: A word write to byte address 8·i followed by a word write to 8·i+4 commits {second, first} at index i. The check code stored with it is the XOR of the eight data bytes. `busy` is 1 from the first accepted word until the pair is committed or dropped. The read port returns data and code one clock after `rd_idx` is presented.
- R3: Writing a pair to an index that is already programmed succeeds only when all 64 bits are zero. Any other value sets `err_flags[0]` (program error) and leaves the stored value unchanged.
- R4: A write with `wr_size` 0 (byte) or 1 (half-word) sets `err_flags[1]` (size error) and programs nothing; only `wr_size` 2 is a word. A size error on a second word drops the pair.
- R5: A first word whose address has `wr_addr[2:0]` not equal to 0 sets `err_flags[2]` (alignment error). The same flag is set, and the pair dropped, when the second word's address is not the first word's address plus 4.
- R6: With `secure_en` 1, a write from requester 0 to an index at or above `sec_start_idx` is ignored with no flag and no state change, and `illegal_evt` is 1 for exactly the following cycle. Requester 1 may program there.
- R7: A write with `wr_req_priv` 0 to a page whose `priv_pages` bit is 1 is ignored with no flag. Page p covers indices p·PAGE_DW to p·PAGE_DW+PAGE_DW−1.
- R8: If the target's secure-region status or page-privilege bit differs at the second word from its value at the first word, the block locks: `busy` stays 1, no error flag is raised, and all later writes and erase starts are ignored until reset.
- R9: A first word or an erase start that arrives while any error flag is set raises `err_flags[3]` (sequence error) and does not start. Writing 1 to an `err_clr` bit clears that flag.
- R10: Pulsing `start_strobe` with `cfg_mass_erase` 1 while idle erases the whole array. `busy` is 1 for exactly DEPTH cycles, after which every index reads erased.
- R11: While `pe_suspend` is 1, neither a first word nor an erase start is accepted, and no flag is set.
- R12: While `cfg_pgm_en` is 0, array writes are ignored with no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Bus write strobe toward the array |
| wr_addr | input | AW (8) | Byte address of the write |
| wr_data | input | 32 | Write data |
| wr_size | input | 2 | 0 byte, 1 half-word, 2 word |
| wr_req_sec | input | 1 | Requester: 0 non-secure, 1 secure |
| wr_req_priv | input | 1 | Write is privileged |
| cfg_pgm_en | input | 1 | Program enable |
| cfg_mass_erase | input | 1 | Selects mass erase for the next start |
| start_strobe | input | 1 | Start pulse for the erase |
| pe_suspend | input | 1 | Program/erase suspended |
| secure_en | input | 1 | Secure mode on |
| sec_start_idx | input | IW+1 (6) | First index of the secure region |
| priv_pages | input | NPAGE (4) | Per-page privileged bit |
| err_clr | input | 4 | Write-1-to-clear for the error flags |
| rd_idx | input | IW (5) | Read index |
| rd_dword | output | 64 | Read data |
| rd_check | output | 8 | Read check code |
| busy | output | 1 | Operation in progress or locked |
| err_flags | output | 4 | Bit 0 program, 1 size, 2 alignment, 3 sequence |
| illegal_evt | output | 1 | One-cycle pulse on a refused secure write |

## Verification
The bench targets the rules that act on the second half of a pair. It tries a nonzero overwrite, where a faulty design would corrupt the cell instead of flagging it. It tries an all-zero overwrite, where an over-strict design would raise a spurious error. It sends a second word at the wrong address, which a loose design would commit into the wrong cell. It also changes a page's privilege between the two halves. A wrong design here would either commit the pair or raise a flag, where the correct behaviour is to hang silently.

Other tests cover refused secure and privileged writes. These must leave the cell erased and must not raise a flag. The secure refusal must also produce the event pulse for exactly one cycle. Further tests check the sequence error when a stale flag is still set, the suspend and program-enable gates, and the erase duration. The erase must hold busy for exactly DEPTH cycles; an off-by-one in the erase counter would show up as a length of DEPTH±1.

// File: rtl/dwp_pkg.sv
package dwp_pkg;
  localparam int unsigned NFLAGS  = 4;
  localparam int unsigned F_PROG  = 0;
  localparam int unsigned F_SIZE  = 1;
  localparam int unsigned F_ALIGN = 2;
  localparam int unsigned F_SEQ   = 3;

  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef struct packed {
    logic sec;
    logic priv;
  } rights_t;

  // placeholder check code: bytewise parity across the double-word
  function automatic logic [7:0] chk_code(input logic [63:0] d);
    logic [7:0] acc;
    acc = 8'h00;
    for (int b = 0; b < 8; b++) acc ^= d[8*b +: 8];
    return acc;
  endfunction
endpackage

// File: rtl/dwp_rules.sv
module dwp_rules
  import dwp_pkg::*;
#(
  parameter int DEPTH   = 32,
  parameter int PAGE_DW = 8,
  localparam int NPAGE  = DEPTH / PAGE_DW,
  localparam int IW     = $clog2(DEPTH),
  localparam int PGW    = (NPAGE > 1) ? $clog2(NPAGE) : 1
) (
  input  logic [IW-1:0]    idx,
  input  logic             secure_en,
  input  logic [IW:0]      sec_start_idx,
  input  logic [NPAGE-1:0] priv_pages,
  output rights_t          rights
);
  logic page_priv;

  generate
    if (NPAGE > 1) begin : g_multi
      assign page_priv = priv_pages[idx[IW-1 -: PGW]];
    end else begin : g_single
      assign page_priv = priv_pages[0];
    end
  endgenerate

  assign rights.sec  = secure_en && ({1'b0, idx} >= sec_start_idx);
  assign rights.priv = page_priv;
endmodule

// File: rtl/dwp_store.sv
module dwp_store #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 72,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dwp_eraser.sv
module dwp_eraser #(
  parameter int DEPTH = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  output logic          active,
  output logic          clr_en,
  output logic [IW-1:0] clr_idx
);
  logic [IW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (act_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == IW'(DEPTH - 1)) act_q <= 1'b0;
    end else if (go) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end
  end

  assign active  = act_q;
  assign clr_en  = act_q;
  assign clr_idx = cnt_q;

  a_r10_erase_starts_clean: assert property (@(posedge clk) disable iff (rst)
    (go && !act_q) |=> (act_q && cnt_q == '0));
endmodule

// File: rtl/dwp_ctrl.sv
module dwp_ctrl
  import dwp_pkg::*;
#(
  parameter int DEPTH   = 32,
  parameter int PAGE_DW = 8,
  localparam int NPAGE  = DEPTH / PAGE_DW,
  localparam int IW     = $clog2(DEPTH),
  localparam int AW     = IW + 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_valid,
  input  logic [AW-1:0]    wr_addr,
  input  logic [31:0]      wr_data,
  input  logic [1:0]       wr_size,
  input  logic             wr_req_sec,
  input  logic             wr_req_priv,
  input  logic             cfg_pgm_en,
  input  logic             cfg_mass_erase,
  input  logic             start_strobe,
  input  logic             pe_suspend,
  input  logic             secure_en,
  input  logic [IW:0]      sec_start_idx,
  input  logic [NPAGE-1:0] priv_pages,
  input  logic [NFLAGS-1:0] err_clr,
  input  logic [IW-1:0]    rd_idx,
  output logic [63:0]      rd_dword,
  output logic [7:0]       rd_check,
  output logic             busy,
  output logic [NFLAGS-1:0] err_flags,
  output logic             illegal_evt
);
  localparam int EW = 72;

  // pair latch and status state
  logic              pending_q, stuck_q, evt_q, rd_prog_q;
  logic [31:0]       lo_q;
  logic [IW-1:0]     pidx_q;
  rights_t           prights_q;
  logic [NFLAGS-1:0] flags_q;
  logic [DEPTH-1:0]  prog_bits;

  // decoded targets
  logic [IW-1:0] w_idx;
  rights_t       w_rights, p_rights;
  logic          w_deny_sec, w_deny_priv;

  // erase engine
  logic          erasing, clr_en, erase_go;
  logic [IW-1:0] clr_idx;

  // decisions
  logic [NFLAGS-1:0] set_flags;
  logic              start_pair, commit, drop_pair, go_stuck, evt;
  logic [63:0]       pair_dw;
  logic [EW-1:0]     store_wdata, store_rdata;

  assign w_idx   = wr_addr[AW-1:3];
  assign pair_dw = {wr_data, lo_q};

  dwp_rules #(.DEPTH(DEPTH), .PAGE_DW(PAGE_DW)) u_rules_wr (
    .idx(w_idx), .secure_en(secure_en), .sec_start_idx(sec_start_idx),
    .priv_pages(priv_pages), .rights(w_rights));

  dwp_rules #(.DEPTH(DEPTH), .PAGE_DW(PAGE_DW)) u_rules_pair (
    .idx(pidx_q), .secure_en(secure_en), .sec_start_idx(sec_start_idx),
    .priv_pages(priv_pages), .rights(p_rights));

  assign w_deny_sec  = w_rights.sec && !wr_req_sec;
  assign w_deny_priv = w_rights.priv && !wr_req_priv;

  always_comb begin
    set_flags  = '0;
    start_pair = 1'b0;
    commit     = 1'b0;
    drop_pair  = 1'b0;
    go_stuck   = 1'b0;
    evt        = 1'b0;
    erase_go   = 1'b0;
    if (wr_valid && !stuck_q && !erasing && cfg_pgm_en) begin
      if (!pending_q) begin
        if (pe_suspend) begin
          start_pair = 1'b0;
        end else if (|flags_q) begin
          set_flags[F_SEQ] = 1'b1;
        end else if (wr_size != SZ_WORD) begin
          set_flags[F_SIZE] = 1'b1;
        end else if (w_deny_sec) begin
          evt = 1'b1;
        end else if (w_deny_priv) begin
          start_pair = 1'b0;
        end else if (wr_addr[2:0] != 3'b000) begin
          set_flags[F_ALIGN] = 1'b1;
        end else begin
          start_pair = 1'b1;
        end
      end else begin
        if (wr_size != SZ_WORD) begin
          set_flags[F_SIZE] = 1'b1;
          drop_pair = 1'b1;
        end else if (wr_addr != {pidx_q, 3'b100}) begin
          set_flags[F_ALIGN] = 1'b1;
          drop_pair = 1'b1;
        end else if (p_rights != prights_q) begin
          go_stuck = 1'b1;
        end else if (w_deny_sec) begin
          evt = 1'b1;
        end else if (w_deny_priv) begin
          commit = 1'b0;
        end else if (prog_bits[pidx_q] && (pair_dw != 64'd0)) begin
          set_flags[F_PROG] = 1'b1;
          drop_pair = 1'b1;
        end else begin
          commit = 1'b1;
        end
      end
    end else if (start_strobe && cfg_mass_erase && !wr_valid && !busy && !pe_suspend) begin
      if (|flags_q) set_flags[F_SEQ] = 1'b1;
      else          erase_go = 1'b1;
    end
  end

  dwp_eraser #(.DEPTH(DEPTH)) u_eraser (
    .clk(clk), .rst(rst), .go(erase_go),
    .active(erasing), .clr_en(clr_en), .clr_idx(clr_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= 1'b0;
      stuck_q   <= 1'b0;
      evt_q     <= 1'b0;
      lo_q      <= '0;
      pidx_q    <= '0;
      prights_q <= '0;
      flags_q   <= '0;
      prog_bits <= '0;
      rd_prog_q <= 1'b0;
    end else begin
      evt_q     <= evt;
      flags_q   <= (flags_q & ~err_clr) | set_flags;
      rd_prog_q <= prog_bits[rd_idx];
      if (go_stuck) stuck_q <= 1'b1;
      if (start_pair) begin
        pending_q <= 1'b1;
        lo_q      <= wr_data;
        pidx_q    <= w_idx;
        prights_q <= w_rights;
      end else if (commit || drop_pair || go_stuck) begin
        pending_q <= 1'b0;
      end
      if (clr_en) prog_bits[clr_idx] <= 1'b0;
      if (commit) prog_bits[pidx_q]  <= 1'b1;
    end
  end

  assign store_wdata = {chk_code(pair_dw), pair_dw};

  dwp_store #(.DEPTH(DEPTH), .WIDTH(EW)) u_store (
    .clk(clk), .we(commit), .waddr(pidx_q), .wdata(store_wdata),
    .raddr(rd_idx), .rdata(store_rdata));

  assign rd_dword    = rd_prog_q ? store_rdata[63:0]  : '1;
  assign rd_check    = rd_prog_q ? store_rdata[71:64] : '1;
  assign busy        = pending_q | stuck_q | erasing;
  assign err_flags   = flags_q;
  assign illegal_evt = evt_q;

  // R8: lock persists and keeps busy high
  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    stuck_q |=> (stuck_q && busy));
  // R8: entering the lock raises no flag
  a_r8_lock_silent: assert property (@(posedge clk) disable iff (rst)
    $rose(stuck_q) |-> ((err_flags & ~$past(err_flags)) == '0));
  // R6: event only after a non-secure write in secure mode
  a_r6_evt_cause: assert property (@(posedge clk) disable iff (rst)
    illegal_evt |-> $past(wr_valid && !wr_req_sec && secure_en));
  // R11: suspend keeps an idle block idle
  a_r11_suspend_idle: assert property (@(posedge clk) disable iff (rst)
    (pe_suspend && !busy) |=> !busy);
  // R12: program disable keeps an idle block idle without an erase start
  a_r12_pgm_off_idle: assert property (@(posedge clk) disable iff (rst)
    (!cfg_pgm_en && !busy && !start_strobe) |=> !busy);
  // R3: a programmed cell only ever receives zeros
  a_r3_zero_overwrite: assert property (@(posedge clk) disable iff (rst)
    (commit && prog_bits[pidx_q]) |-> (store_wdata[63:0] == 64'd0));
  // R4: a non-word write outside an erase leaves the programmed map alone
  a_r4_size_no_commit: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_size != SZ_WORD && !erasing) |=> $stable(prog_bits));
endmodule

// File: tb/dwp_ctrl_bench.sv
module dwp_ctrl_bench;
  localparam int DEPTH = 32;
  localparam int PAGE_DW = 8;
  localparam int NPAGE = DEPTH / PAGE_DW;
  localparam int IW = $clog2(DEPTH);
  localparam int AW = IW + 3;

  logic clk = 0, rst = 1;
  logic wr_valid = 0, wr_req_sec = 0, wr_req_priv = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0] wr_size = 2'd2;
  logic cfg_pgm_en = 1, cfg_mass_erase = 0, start_strobe = 0, pe_suspend = 0, secure_en = 0;
  logic [IW:0] sec_start_idx = (IW+1)'(DEPTH);
  logic [NPAGE-1:0] priv_pages = '0;
  logic [3:0] err_clr = '0;
  logic [IW-1:0] rd_idx = '0;
  logic [63:0] rd_dword;
  logic [7:0] rd_check;
  logic busy, illegal_evt;
  logic [3:0] err_flags;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  dwp_ctrl #(.DEPTH(DEPTH), .PAGE_DW(PAGE_DW)) u_dwp_ctrl (.*);

  function automatic logic [7:0] xor_bytes(input logic [63:0] d);
    logic [7:0] a = 0;
    for (int i = 0; i < 8; i++) a ^= d[8*i +: 8];
    return a;
  endfunction

  task automatic check(input string tag, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] d, input logic [1:0] sz,
                    input logic sec, input logic priv);
    @(negedge clk);
    wr_valid = 1; wr_addr = AW'(addr); wr_data = d; wr_size = sz;
    wr_req_sec = sec; wr_req_priv = priv;
    @(posedge clk); @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic pair(input int idx, input logic [63:0] d, input logic sec, input logic priv);
    wr(idx*8, d[31:0], 2'd2, sec, priv);
    wr(idx*8+4, d[63:32], 2'd2, sec, priv);
  endtask

  task automatic rd(input int idx, output logic [63:0] d, output logic [7:0] c);
    @(negedge clk); rd_idx = IW'(idx);
    @(posedge clk); @(negedge clk);
    d = rd_dword; c = rd_check;
  endtask

  task automatic clear_flags();
    @(negedge clk); err_clr = 4'hF;
    @(posedge clk); @(negedge clk); err_clr = 4'h0;
  endtask

  task automatic t_reset();
    logic [63:0] d; logic [7:0] c;
    check("R1 busy", 72'(busy), 72'(0));
    check("R1 flags", 72'(err_flags), 72'(0));
    check("R1 evt", 72'(illegal_evt), 72'(0));
    rd(7, d, c);
    check("R1 erased read", {c, d}, {8'hFF, 64'hFFFF_FFFF_FFFF_FFFF});
  endtask

  task automatic t_program();
    logic [63:0] d; logic [7:0] c;
    logic [63:0] v = 64'h1234_5678_A5A5_0F0F;
    wr(8, v[31:0], 2'd2, 0, 0);
    check("R2 busy after first word", 72'(busy), 72'(1));
    wr(12, v[63:32], 2'd2, 0, 0);
    check("R2 busy after commit", 72'(busy), 72'(0));
    check("R2 no flags", 72'(err_flags), 72'(0));
    rd(1, d, c);
    check("R2 stored entry", {c, d}, {xor_bytes(v), v});
  endtask

  task automatic t_overwrite();
    logic [63:0] d; logic [7:0] c;
    logic [63:0] v = 64'h1234_5678_A5A5_0F0F;
    pair(1, 64'h0000_0000_0000_0001, 0, 0);
    check("R3 nonzero overwrite flag", 72'(err_flags), 72'(4'b0001));
    rd(1, d, c);
    check("R3 cell unchanged", {c, d}, {xor_bytes(v), v});
    clear_flags();
    check("R9 flags cleared", 72'(err_flags), 72'(0));
    pair(1, 64'd0, 0, 0);
    check("R3 zero overwrite no flag", 72'(err_flags), 72'(0));
    rd(1, d, c);
    check("R3 zero overwrite stored", {c, d}, 72'd0);
  endtask

  task automatic t_size();
    logic [63:0] d; logic [7:0] c;
    wr(16, 32'hDEAD_BEEF, 2'd0, 0, 0);
    check("R4 byte size flag", 72'(err_flags), 72'(4'b0010));
    clear_flags();
    wr(16, 32'hDEAD_BEEF, 2'd2, 0, 0);
    wr(20, 32'h0000_BEEF, 2'd1, 0, 0);
    check("R4 half on second word", {68'(err_flags), 4'(busy)}, {68'(4'b0010), 4'(0)});
    clear_flags();
    rd(2, d, c);
    check("R4 nothing programmed", {c, d}, {8'hFF, 64'hFFFF_FFFF_FFFF_FFFF});
  endtask

  task automatic t_align();
    logic [63:0] d; logic [7:0] c;
    wr(20, 32'h1111_1111, 2'd2, 0, 0);
    check("R5 misaligned first", {68'(err_flags), 4'(busy)}, {68'(4'b0100), 4'(0)});
    clear_flags();
    wr(24, 32'h2222_2222, 2'd2, 0, 0);
    wr(32, 32'h3333_3333, 2'd2, 0, 0);
    check("R5 wrong second address", {68'(err_flags), 4'(busy)}, {68'(4'b0100), 4'(0)});
    clear_flags();
    rd(3, d, c);
    check("R5 idx3 erased", {c, d}, {8'hFF, 64'hFFFF_FFFF_FFFF_FFFF});
    rd(4, d, c);
    check("R5 idx4 erased", {c, d}, {8'hFF, 64'hFFFF_FFFF_FFFF_FFFF});
  endtask

  task automatic t_seq();
    logic [63:0] d; logic [7:0] c;
    wr(40, 32'h1, 2'd0, 0, 0);
    wr(40, 32'h1, 2'd2, 0, 0);
    check("R9 sequence flag", {68'(err_flags), 4'(busy)}, {68'(4'b1010), 4'(0)});
    @(negedge clk); cfg_mass_erase = 1; start_strobe = 1;
    @(posedge clk); @(negedge clk); start_strobe = 0; cfg_mass_erase = 0;
    check("R9 erase refused", 72'(busy), 72'(0));
    clear_flags();
    rd(5, d, c);
    check("R9 not programmed", {c, d}, {8'hFF, 64'hFFFF_FFFF_FFFF_FFFF});
  endtask

  task automatic t_pgm_off();
    logic [63:0] d; logic [7:0] c;
    cfg_pgm_en = 0;
    pair(6, 64'h55, 0, 0);
    check("R12 disabled no flag", {68'(err_flags), 4'(busy)}, 72'd0);
    cfg_pgm_en = 1;
    rd(6, d, c);
    check("R12 disabled not programmed", {c, d}, {8'hFF, 64'hFFFF_FFFF_FFFF_FFFF});
  endtask

  task automatic t_secure();
    logic [63:0] d; logic [7:0] c;
    logic [63:0] v = 64'hCAFE_0000_0000_F00D;
    secure_en = 1; sec_start_idx = 6'd16;
    wr(20*8, 32'h77, 2'd2, 0, 1);
    check("R6 event pulse", {68'(illegal_evt), 4'(busy)}, {68'(1), 4'(0)});
    @(negedge clk);
    check("R6 event one cycle", 72'(illegal_evt), 72'(0));
    check("R6 no flag", 72'(err_flags), 72'(0));
    rd(20, d, c);
    check("R6 refused cell erased", {c, d}, {8'hFF, 64'hFFFF_FFFF_FFFF_FFFF});
    pair(20, v, 1, 1);
    rd(20, d, c);
    check("R6 secure requester writes", {c, d}, {xor_bytes(v), v});
    secure_en = 0;
  endtask

  task automatic t_priv();
    logic [63:0] d; logic [7:0] c;
    logic [63:0] v = 64'h0BAD_F00D_1357_9BDF;
    priv_pages = 4'b0010;
    wr(9*8, 32'h9, 2'd2, 0, 0);
    check("R7 unprivileged ignored", {68'(err_flags), 4'(busy)}, 72'd0);
    rd(9, d, c);
    check("R7 cell erased", {c, d}, {8'hFF, 64'hFFFF_FFFF_FFFF_FFFF});
    pair(9, v, 0, 1);
    rd(9, d, c);
    check("R7 privileged writes", {c, d}, {xor_bytes(v), v});
    priv_pages = 4'b0000;
  endtask

  task automatic t_suspend();
    pe_suspend = 1;
    wr(10*8, 32'h1, 2'd2, 0, 0);
    check("R11 write blocked", {68'(err_flags), 4'(busy)}, 72'd0);
    @(negedge clk); cfg_mass_erase = 1; start_strobe = 1;
    @(posedge clk); @(negedge clk); start_strobe = 0; cfg_mass_erase = 0;
    check("R11 erase blocked", {68'(err_flags), 4'(busy)}, 72'd0);
    pe_suspend = 0;
  endtask

  task automatic t_erase();
    logic [63:0] d; logic [7:0] c;
    int n = 0;
    @(negedge clk); cfg_mass_erase = 1; start_strobe = 1;
    @(posedge clk); @(negedge clk); start_strobe = 0; cfg_mass_erase = 0;
    while (busy && n < 200) begin n++; @(negedge clk); end
    check("R10 busy length", 72'(n), 72'(DEPTH));
    rd(20, d, c);
    check("R10 idx20 erased", {c, d}, {8'hFF, 64'hFFFF_FFFF_FFFF_FFFF});
    rd(9, d, c);
    check("R10 idx9 erased", {c, d}, {8'hFF, 64'hFFFF_FFFF_FFFF_FFFF});
  endtask

  task automatic t_lock();
    logic [63:0] d; logic [7:0] c;
    wr(4*8, 32'hAAAA, 2'd2, 1, 1);
    priv_pages = 4'b0001;
    wr(4*8+4, 32'hBBBB, 2'd2, 1, 1);
    repeat (10) @(negedge clk);
    check("R8 locked busy, no flag", {68'(err_flags), 4'(busy)}, {68'(0), 4'(1)});
    priv_pages = 4'b0000;
    pair(12, 64'h1, 0, 1);
    rd(12, d, c);
    check("R8 writes ignored while locked", {c, d}, {8'hFF, 64'hFFFF_FFFF_FFFF_FFFF});
    rd(4, d, c);
    check("R8 pair not committed", {c, d}, {8'hFF, 64'hFFFF_FFFF_FFFF_FFFF});
    @(negedge clk); rst = 1;
    @(posedge clk); @(negedge clk); rst = 0;
    check("R8 reset releases lock", 72'(busy), 72'(0));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset();
    t_program();
    t_overwrite();
    t_size();
    t_align();
    t_seq();
    t_pgm_off();
    t_secure();
    t_priv();
    t_suspend();
    t_erase();
    t_lock();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule